// File: doc/BRIEF.md
# Control-Register Bus Target

This block is the target end of a narrow parallel bus that configures a serial PHY. A single 16-bit input carries both addresses and data. Four one-bit strobes select the operation: capture an address, capture a data word, read, or commit a write. The block keeps a latched address and a held data word. It holds a small bank of 16-bit registers placed in a sparse 16-bit address space. Every strobe is finished with a four-phase request/acknowledge exchange.

A host writes in three handshakes: it captures the address, then captures the data, then raises the commit strobe. A read takes two handshakes: it captures the address, then raises the read strobe, and the register contents appear on the output while acknowledge is high. The acknowledge is held back a parameterised number of cycles to model a slow internal access. Strobes that break the one-at-a-time rule are ignored and raise a sticky error flag. All inputs are taken as synchronous to the clock.

Top module: `crbus_target`

## Requirements
- R1: After reset, ack, protoErr and dataOut are 0. Implemented register i (0 to NUM_REGS-1) sits at address BASE_ADDR+i and resets to RESET_BASE+i. The defaults are 0x1000 and 0x5A00, with 8 registers.
- R2: A rising capture-address strobe latches dataIn as the current address. ack rises ACK_DELAY clock edges after the edge that first samples the strobe high. With ACK_DELAY=2, ack is seen at the third falling edge after the strobe is driven.
- R3: Once ack is high, it stays high for as long as the strobe of the current operation is held.
- R4: After the strobe of the current operation is sampled low, ack goes low on the next edge. Only then is a new strobe accepted.
- R5: A rising capture-data strobe loads dataIn into a holding register and leaves every addressed register unchanged.
- R6: A rising write strobe copies the held word into the register at the latched address.
- R7: A rising read strobe places the contents of the register at the latched address on dataOut. That value is present when ack rises and stays constant while ack is high.
- R8: A read of an address with no implemented register, including 0xFFFF and BASE_ADDR+NUM_REGS, returns 0x0000. A write commit to such an address is acknowledged and changes no register.
- R9: A strobe that rises while an operation is in progress (from acceptance until ack is low again) sets protoErr and is ignored. protoErr then stays 1 until reset.
- R10: Two or more strobes high when one of them rises with the block idle set protoErr. No operation starts and no ack is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 16 | Shared address/data input |
| capAddrStb | input | 1 | Capture-address strobe |
| capDataStb | input | 1 | Capture-data strobe |
| readStb | input | 1 | Read strobe |
| writeStb | input | 1 | Write-commit strobe |
| dataOut | output | 16 | Read data, valid while ack is high |
| ack | output | 1 | Four-phase acknowledge |
| protoErr | output | 1 | Sticky protocol-violation flag |

## Verification
A corrupted latched address or holding word stays hidden until the next read. It then shows up as a wrong dataOut value at the very edge where ack rises, so every write is followed by a read-back. A stuck or skipped handshake state shows at once as a wrong ack latency, or as an ack that fails to fall one edge after release. Those cycle counts are measured on every operation. An illegally accepted strobe is caught one edge later through protoErr, and later through the unchanged register contents that a read exposes.

// File: rtl/crbus_pkg.sv
package crbus_pkg;

  localparam int DATA_W = 16;

  // one-cycle actions issued by the control to the datapath
  typedef struct packed {
    logic ldAddr;
    logic ldData;
    logic commit;
    logic rdLoad;
  } dpCmd_t;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACK  = 2'd2
  } hsState_e;

  // strobe vector bit positions
  localparam int SB_ADDR = 0;
  localparam int SB_DATA = 1;
  localparam int SB_READ = 2;
  localparam int SB_WRITE = 3;
  localparam int SB_NUM = 4;

endpackage

// File: rtl/crbus_ctrl.sv
module crbus_ctrl
  import crbus_pkg::*;
#(
  parameter int ACK_DELAY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SB_NUM-1:0] strbIn,
  output dpCmd_t            cmd,
  output logic              ack,
  output logic              protoErr
);

  localparam int CNT_W = (ACK_DELAY < 2) ? 1 : $clog2(ACK_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_DELAY - 1);

  hsState_e          stateQ;
  logic [CNT_W-1:0]  cntQ;
  logic [SB_NUM-1:0] prevQ;
  logic [SB_NUM-1:0] opQ;
  logic              ackQ;
  logic              errQ;

  logic [SB_NUM-1:0] riseVec;
  logic              anyRise;
  logic              acceptEn;
  logic              errEn;
  logic              activeLevel;

  assign riseVec     = strbIn & ~prevQ;
  assign anyRise     = |riseVec;
  assign acceptEn    = (stateQ == HS_IDLE) && anyRise && ($countones(strbIn) == 1);
  assign errEn       = anyRise && !acceptEn;
  assign activeLevel = |(strbIn & opQ);

  always_comb begin
    cmd = '0;
    if (acceptEn) begin
      cmd.ldAddr = riseVec[SB_ADDR];
      cmd.ldData = riseVec[SB_DATA];
      cmd.rdLoad = riseVec[SB_READ];
      cmd.commit = riseVec[SB_WRITE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= HS_IDLE;
      cntQ   <= '0;
      prevQ  <= '0;
      opQ    <= '0;
      ackQ   <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      prevQ <= strbIn;
      errQ  <= errQ | errEn;
      unique case (stateQ)
        HS_IDLE: begin
          if (acceptEn) begin
            opQ    <= strbIn;
            cntQ   <= CNT_LOAD;
            stateQ <= HS_WAIT;
          end
        end
        HS_WAIT: begin
          if (cntQ == '0) begin
            stateQ <= HS_ACK;
            ackQ   <= 1'b1;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        HS_ACK: begin
          if (!activeLevel) begin
            stateQ <= HS_IDLE;
            ackQ   <= 1'b0;
          end
        end
        default: stateQ <= HS_IDLE;
      endcase
    end
  end

  assign ack      = ackQ;
  assign protoErr = errQ;

  // R3: acknowledge persists while the owning strobe is held
  a_r3_ack_held : assert property (@(posedge clk) disable iff (!rstN)
    (ack && activeLevel) |=> ack);

  // R4: acknowledge drops one edge after the owning strobe is released
  a_r4_ack_drop : assert property (@(posedge clk) disable iff (!rstN)
    (ack && !activeLevel) |=> !ack);

  // R9: the error flag never clears outside reset
  a_r9_err_sticky : assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

endmodule

// File: rtl/crbus_regfile.sv
module crbus_regfile
  import crbus_pkg::*;
#(
  parameter int                NUM_REGS   = 8,
  parameter logic [DATA_W-1:0] BASE_ADDR  = 16'h1000,
  parameter logic [DATA_W-1:0] RESET_BASE = 16'h5A00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  dpCmd_t            cmd,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0]                addrQ;
  logic [DATA_W-1:0]                holdQ;
  logic [DATA_W-1:0]                rdQ;
  logic [NUM_REGS-1:0]              hit;
  logic [NUM_REGS-1:0][DATA_W-1:0]  bank;
  logic [DATA_W-1:0]                rdVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      holdQ <= '0;
      rdQ   <= '0;
    end else begin
      if (cmd.ldAddr) addrQ <= dataIn;
      if (cmd.ldData) holdQ <= dataIn;
      if (cmd.rdLoad) rdQ   <= rdVal;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] REG_ADDR = BASE_ADDR + DATA_W'(i);
    localparam logic [DATA_W-1:0] REG_RST  = RESET_BASE + DATA_W'(i);
    logic [DATA_W-1:0] valQ;

    assign hit[i] = (addrQ == REG_ADDR);

    always_ff @(posedge clk) begin
      if (!rstN)                   valQ <= REG_RST;
      else if (cmd.commit && hit[i]) valQ <= holdQ;
    end

    assign bank[i] = valQ;
  end

  always_comb begin
    rdVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) rdVal = rdVal | bank[i];
    end
  end

  assign dataOut = rdQ;

  // R10: the control never issues two datapath actions at once
  a_r10_single_action : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.ldAddr, cmd.ldData, cmd.commit, cmd.rdLoad}));

  // R5: capturing data leaves the latched address alone
  a_r5_addr_kept : assert property (@(posedge clk) disable iff (!rstN)
    (cmd.ldData) |=> $stable(addrQ));

endmodule

// File: rtl/crbus_target.sv
module crbus_target
  import crbus_pkg::*;
#(
  parameter int                NUM_REGS   = 8,
  parameter logic [DATA_W-1:0] BASE_ADDR  = 16'h1000,
  parameter logic [DATA_W-1:0] RESET_BASE = 16'h5A00,
  parameter int                ACK_DELAY  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              capAddrStb,
  input  logic              capDataStb,
  input  logic              readStb,
  input  logic              writeStb,
  output logic [DATA_W-1:0] dataOut,
  output logic              ack,
  output logic              protoErr
);

  logic [SB_NUM-1:0] strbVec;
  dpCmd_t            cmd;

  always_comb begin
    strbVec           = '0;
    strbVec[SB_ADDR]  = capAddrStb;
    strbVec[SB_DATA]  = capDataStb;
    strbVec[SB_READ]  = readStb;
    strbVec[SB_WRITE] = writeStb;
  end

  crbus_ctrl #(
    .ACK_DELAY(ACK_DELAY)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strbIn  (strbVec),
    .cmd     (cmd),
    .ack     (ack),
    .protoErr(protoErr)
  );

  crbus_regfile #(
    .NUM_REGS  (NUM_REGS),
    .BASE_ADDR (BASE_ADDR),
    .RESET_BASE(RESET_BASE)
  ) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .cmd    (cmd),
    .dataOut(dataOut)
  );

  // R7: read data does not move while acknowledge stays high
  a_r7_rdata_stable : assert property (@(posedge clk) disable iff (!rstN)
    (ack && $past(ack)) |-> $stable(dataOut));

endmodule

// File: tb/tb_crbus_target.sv
`timescale 1ns/1ps
module tb_crbus_target;

  localparam int          ACK_DELAY = 2;
  localparam logic [15:0] BASE      = 16'h1000;
  localparam int          NUM       = 8;
  localparam logic [15:0] RST       = 16'h5A00;

  localparam int OP_ADDR = 0;
  localparam int OP_DATA = 1;
  localparam int OP_READ = 2;
  localparam int OP_WRITE = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dataIn = '0;
  logic        capAddrStb = 1'b0;
  logic        capDataStb = 1'b0;
  logic        readStb = 1'b0;
  logic        writeStb = 1'b0;
  logic [15:0] dataOut;
  logic        ack;
  logic        protoErr;

  always #2 clk = ~clk;

  crbus_target #(
    .NUM_REGS(NUM), .BASE_ADDR(BASE), .RESET_BASE(RST), .ACK_DELAY(ACK_DELAY)
  ) dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn),
    .capAddrStb(capAddrStb), .capDataStb(capDataStb),
    .readStb(readStb), .writeStb(writeStb),
    .dataOut(dataOut), .ack(ack), .protoErr(protoErr)
  );

  typedef struct {
    logic        isRead;
    logic [15:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int nCmp = 0;
  int nBad = 0;
  logic ackPrev = 1'b0;

  task automatic check(input logic ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: consumes one expected item per acknowledge
  always @(negedge clk) begin
    if (rstN && ack && !ackPrev) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected acknowledge", 16'h1, 16'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (it.isRead) check(dataOut == it.val, it.tag, dataOut, it.val);
      end
    end
    ackPrev = ack;
  end

  task automatic setStrobe(input int which, input logic v);
    case (which)
      OP_ADDR:  capAddrStb = v;
      OP_DATA:  capDataStb = v;
      OP_READ:  readStb    = v;
      default:  writeStb   = v;
    endcase
  endtask

  task automatic op(input int which, input logic [15:0] d, input int hold,
                    input logic isRead, input logic [15:0] expVal, input string tag);
    expItem_t it;
    int cnt;
    logic [15:0] snap;
    it.isRead = isRead;
    it.val    = expVal;
    it.tag    = tag;
    expQ.push_back(it);
    @(negedge clk);
    dataIn = d;
    setStrobe(which, 1'b1);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!ack && cnt < 20);
    check(cnt == ACK_DELAY + 1, "R2 acknowledge latency", 16'(cnt), 16'(ACK_DELAY + 1));
    for (int h = 0; h < hold; h++) begin
      snap = dataOut;
      @(negedge clk);
      check(ack, "R3 acknowledge held", {15'd0, ack}, 16'd1);
      check(dataOut == snap, "R7 read data stable", dataOut, snap);
    end
    setStrobe(which, 1'b0);
    @(negedge clk);
    check(!ack, "R4 acknowledge released", {15'd0, ack}, 16'd0);
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [15:0] d);
    op(OP_ADDR, a, 0, 1'b0, '0, "R2 address");
    op(OP_DATA, d, 0, 1'b0, '0, "R5 data");
    op(OP_WRITE, 16'h0, 0, 1'b0, '0, "R6 commit");
  endtask

  task automatic readReg(input logic [15:0] a, input logic [15:0] e, input string tag);
    op(OP_ADDR, a, 0, 1'b0, '0, "R2 address");
    op(OP_READ, 16'h0, 0, 1'b1, e, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    capAddrStb = 1'b0; capDataStb = 1'b0; readStb = 1'b0; writeStb = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!ack, "R1 reset ack", {15'd0, ack}, 16'd0);
    check(!protoErr, "R1 reset protoErr", {15'd0, protoErr}, 16'd0);
    check(dataOut == 16'h0, "R1 reset dataOut", dataOut, 16'h0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
    summary();
  end

  initial begin
    doReset();

    // R1 reset values
    readReg(BASE + 16'd3, RST + 16'd3, "R1 reset value reg3");
    readReg(BASE + 16'd7, RST + 16'd7, "R1 reset value reg7");

    // R5 capture data does not write; R6 commit does
    op(OP_ADDR, BASE + 16'd5, 0, 1'b0, '0, "R2 address");
    op(OP_DATA, 16'hBEEF, 0, 1'b0, '0, "R5 data");
    op(OP_READ, 16'h0, 0, 1'b1, RST + 16'd5, "R5 register untouched by capture");
    op(OP_WRITE, 16'h0, 0, 1'b0, '0, "R6 commit");
    op(OP_READ, 16'h0, 0, 1'b1, 16'hBEEF, "R6 committed value");

    // R6 several patterns
    writeReg(BASE, 16'h1234);
    writeReg(BASE + 16'd7, 16'hFFFF);
    readReg(BASE, 16'h1234, "R6 reg0 written");
    readReg(BASE + 16'd7, 16'hFFFF, "R6 reg7 written");
    readReg(BASE + 16'd5, 16'hBEEF, "R6 reg5 kept");

    // R8 unimplemented addresses
    writeReg(16'h2000, 16'h7777);
    readReg(16'h2000, 16'h0000, "R8 unimplemented read");
    readReg(16'hFFFF, 16'h0000, "R8 top address read");
    readReg(BASE + 16'(NUM), 16'h0000, "R8 one past bank");
    readReg(BASE, 16'h1234, "R8 discarded write left reg0");

    // R3 and R7: hold the read strobe for several cycles
    op(OP_ADDR, BASE + 16'd5, 0, 1'b0, '0, "R2 address");
    op(OP_READ, 16'h0, 5, 1'b1, 16'hBEEF, "R7 read with long hold");

    // R9: strobe during an active acknowledge
    op(OP_ADDR, BASE + 16'd4, 0, 1'b0, '0, "R2 address");
    begin
      expItem_t it;
      it.isRead = 1'b1;
      it.val    = RST + 16'd4;
      it.tag    = "R9 read before violation";
      expQ.push_back(it);
    end
    @(negedge clk);
    readStb = 1'b1;
    while (!ack) @(negedge clk);
    dataIn = BASE;
    capAddrStb = 1'b1;
    @(negedge clk);
    check(protoErr, "R9 error flag set", {15'd0, protoErr}, 16'd1);
    check(ack, "R9 acknowledge unaffected", {15'd0, ack}, 16'd1);
    readStb = 1'b0;
    capAddrStb = 1'b0;
    @(negedge clk);
    check(!ack, "R4 release after violation", {15'd0, ack}, 16'd0);
    op(OP_READ, 16'h0, 0, 1'b1, RST + 16'd4, "R9 ignored address capture");
    check(protoErr, "R9 error flag sticky", {15'd0, protoErr}, 16'd1);

    // reset restores values
    doReset();
    readReg(BASE, RST, "R1 reset restores reg0");

    // R10: two strobes at once with the block idle
    op(OP_ADDR, BASE + 16'd2, 0, 1'b0, '0, "R2 address");
    op(OP_DATA, 16'h9999, 0, 1'b0, '0, "R5 data");
    @(negedge clk);
    dataIn = 16'h4444;
    capDataStb = 1'b1;
    writeStb = 1'b1;
    repeat (ACK_DELAY + 3) @(negedge clk);
    check(!ack, "R10 no acknowledge", {15'd0, ack}, 16'd0);
    check(protoErr, "R10 error flag set", {15'd0, protoErr}, 16'd1);
    capDataStb = 1'b0;
    writeStb = 1'b0;
    @(negedge clk);
    op(OP_READ, 16'h0, 0, 1'b1, RST + 16'd2, "R10 no commit happened");
    op(OP_WRITE, 16'h0, 0, 1'b0, '0, "R6 commit");
    op(OP_READ, 16'h0, 0, 1'b1, 16'h9999, "R10 held data not replaced");

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R2 every operation acknowledged", 16'(expQ.size()), 16'h0);
    summary();
  end

endmodule